// File: doc/BRIEF.md
# Preemptive Task Switch Trigger

This block sits beside the instruction sequencer of a processor that keeps several task contexts in hardware. It decides in which cycle the running task must give up the processor and which program counter that task must later resume from. It counts the instructions the current task has executed since the last switch. When the count reaches a programmable interval it requests a preemptive switch. It also turns a decoded yield instruction into the same switch request.

Preemption is held back while an interrupt service routine runs. The counter keeps its value during that time, so the switch is issued on the first instruction slot after the routine ends. A preemption takes the slot of the instruction about to execute, so the saved resume address is that instruction's own address. A yield completes, so the saved resume address is the instruction after it. Storing and restoring contexts is left to the neighbouring logic, which consumes the one-cycle switch pulse and the resume address.

Top module: `task_switch_trigger`

## Requirements
- R1: The internal instruction count rises by one in each cycle where `insn_valid_i` is high and no switch is decided, stays unchanged when `insn_valid_i` is low, and returns to 0 in the cycle a switch is decided.
- R2: When multitasking is enabled, more than one task is active, no interrupt routine is active, `interval_i` is non-zero and the count is greater than or equal to `interval_i`, a valid instruction slot produces a preemptive switch.
- R3: An `interval_i` of 0 never produces a preemptive switch, whatever the count.
- R4: While `irq_active_i` is high no preemptive switch is issued. A preemption that is due is issued on the first valid instruction slot after `irq_active_i` falls.
- R5: A switch caused only by a yield (`yield_i` high with `insn_valid_i`) saves `next_pc_i` as the resume address.
- R6: A preemptive switch saves `cur_pc_i`, the address of the instruction that does not execute, as the resume address.
- R7: With `mt_enable_i` low or `single_task_i` high, neither a yield nor a due preemption produces a switch. The yield acts as a no-operation.
- R8: When a yield and a due preemption meet in the same slot, exactly one switch is issued and it saves `cur_pc_i`.
- R9: The count saturates at 0xFFFF instead of wrapping, so with an interval of 0xFFFF a preemption still comes due after any longer run.
- R10: `switch_o` is a one-cycle pulse registered one clock after the deciding slot. `resume_pc_o` updates with it and otherwise holds its value. After reset `switch_o` is 0, `resume_pc_o` is 0 and the count is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| insn_valid_i | input | 1 | An instruction at `cur_pc_i` is about to execute this cycle |
| yield_i | input | 1 | The instruction in this slot is a yield |
| irq_active_i | input | 1 | An interrupt service routine is running |
| interval_i | input | CNT_W (16) | Preemption interval in instructions; 0 disables preemption |
| mt_enable_i | input | 1 | Multitasking enable |
| single_task_i | input | 1 | Only one task is active |
| cur_pc_i | input | PC_W (20) | Address of the instruction in this slot |
| next_pc_i | input | PC_W (20) | Address of the instruction that follows it |
| switch_o | output | 1 | One-cycle task switch request |
| resume_pc_o | output | PC_W (20) | Resume address to save for the outgoing task |

## Verification
A yield and a due preemption can fall in the same instruction slot. The same is true of a due preemption and the falling edge of the interrupt flag. The random phase uses a short interval and frequent yields so that yields often land on slots where the count has already reached the interval. Directed steps also place a yield exactly on the due slot. Each such slot is judged by the bench model: it must give exactly one pulse with the current address, and an interrupt that is still active must give no pulse at all. The interrupt case is provoked by holding the flag across the due point and releasing it. The first valid slot after release must carry the preemption.

// File: rtl/tsw_pkg.sv
`timescale 1ns/1ps
// Package: shared types for the task switch trigger.
// Assumes: nothing beyond IEEE 1800-2017.
package tsw_pkg;

    // Kind of switch decided in a slot.
    typedef enum logic [1:0] {
        SW_NONE    = 2'd0,
        SW_YIELD   = 2'd1,
        SW_PREEMPT = 2'd2
    } sw_kind_e;

endpackage

// File: rtl/tsw_insn_counter.sv
`timescale 1ns/1ps
// Module: tsw_insn_counter
// Counts executed instructions since the last switch, saturating at its
// maximum so that a due preemption can never be lost by wrap-around.
// Assumes: clear_i has priority over tick_i in the same cycle.
module tsw_insn_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             clear_i,
    output logic [CNT_W-1:0] count_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] count_q;
    logic [CNT_W-1:0] count_d;
    logic             at_max;

    // Flag the saturation point.
    always_comb at_max = (count_q == CNT_MAX);

    // Next count: clear on switch, else saturating increment on tick.
    always_comb begin
        count_d = count_q;
        if (clear_i) begin
            count_d = '0;
        end else if (tick_i && !at_max) begin
            count_d = count_q + 1'b1;
        end
    end

    // Count register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else begin
            count_q <= count_d;
        end
    end

    assign count_o = count_q;

endmodule

// File: rtl/tsw_switch_arbiter.sv
`timescale 1ns/1ps
// Module: tsw_switch_arbiter
// Combinational decision for one instruction slot: preemption, yield or
// nothing. Preemption outranks the yield that would have executed.
// Assumes: count_i is the number of instructions executed since the last
// switch, excluding the one in the current slot.
module tsw_switch_arbiter
    import tsw_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic [CNT_W-1:0] count_i,
    input  logic [CNT_W-1:0] interval_i,
    input  logic             insn_valid_i,
    input  logic             yield_i,
    input  logic             irq_active_i,
    input  logic             mt_enable_i,
    input  logic             single_task_i,
    output sw_kind_e         kind_o
);

    logic interval_on;
    logic reached;
    logic may_switch;
    logic preempt_go;
    logic yield_go;

    // Preemption is armed only for a non-zero interval.
    always_comb interval_on = (interval_i != '0);

    // Count has met or passed the interval.
    always_comb reached = interval_on && (count_i >= interval_i);

    // A switch needs a live slot, multitasking on and another task to run.
    always_comb may_switch = insn_valid_i && mt_enable_i && !single_task_i;

    // Preemption fires on a due slot outside interrupt service.
    always_comb preempt_go = may_switch && reached && !irq_active_i;

    // Yield fires on a decoded yield in a live slot.
    always_comb yield_go = may_switch && yield_i;

    // Priority encode the slot outcome.
    always_comb begin
        if (preempt_go) begin
            kind_o = SW_PREEMPT;
        end else if (yield_go) begin
            kind_o = SW_YIELD;
        end else begin
            kind_o = SW_NONE;
        end
    end

endmodule

// File: rtl/tsw_resume_select.sv
`timescale 1ns/1ps
// Module: tsw_resume_select
// Registers the switch pulse and picks the resume address: the slot's own
// address for a preemption, the following address for a yield.
// Assumes: kind_i is SW_NONE in every cycle without a switch.
module tsw_resume_select
    import tsw_pkg::*;
#(
    parameter int PC_W = 20
) (
    input  logic            clk,
    input  logic            rst_n,
    input  sw_kind_e        kind_i,
    input  logic [PC_W-1:0] cur_pc_i,
    input  logic [PC_W-1:0] next_pc_i,
    output logic            switch_o,
    output logic [PC_W-1:0] resume_pc_o
);

    logic [PC_W-1:0] pick_pc;
    logic            switch_q;
    logic [PC_W-1:0] resume_q;

    // Choose the address the outgoing task resumes from.
    always_comb pick_pc = (kind_i == SW_PREEMPT) ? cur_pc_i : next_pc_i;

    // Pulse register and held resume address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            switch_q <= 1'b0;
            resume_q <= '0;
        end else begin
            switch_q <= (kind_i != SW_NONE);
            if (kind_i != SW_NONE) begin
                resume_q <= pick_pc;
            end
        end
    end

    assign switch_o    = switch_q;
    assign resume_pc_o = resume_q;

endmodule

// File: rtl/task_switch_trigger.sv
`timescale 1ns/1ps
// Module: task_switch_trigger
// Top of the switch trigger: instruction counter, slot arbiter and resume
// register. Emits a one-cycle switch pulse and the resume address.
// Assumes: one instruction slot per cycle at most; the context store acts
// on switch_o and resume_pc_o one clock after the deciding slot.
module task_switch_trigger
    import tsw_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int PC_W  = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             insn_valid_i,
    input  logic             yield_i,
    input  logic             irq_active_i,
    input  logic [CNT_W-1:0] interval_i,
    input  logic             mt_enable_i,
    input  logic             single_task_i,
    input  logic [PC_W-1:0]  cur_pc_i,
    input  logic [PC_W-1:0]  next_pc_i,
    output logic             switch_o,
    output logic [PC_W-1:0]  resume_pc_o
);

    logic [CNT_W-1:0] insn_count;
    sw_kind_e         slot_kind;
    logic             slot_switch;

    // Any decided switch clears the count.
    always_comb slot_switch = (slot_kind != SW_NONE);

    tsw_insn_counter #(
        .CNT_W (CNT_W)
    ) counter_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (insn_valid_i),
        .clear_i (slot_switch),
        .count_o (insn_count)
    );

    tsw_switch_arbiter #(
        .CNT_W (CNT_W)
    ) arbiter_i (
        .count_i       (insn_count),
        .interval_i    (interval_i),
        .insn_valid_i  (insn_valid_i),
        .yield_i       (yield_i),
        .irq_active_i  (irq_active_i),
        .mt_enable_i   (mt_enable_i),
        .single_task_i (single_task_i),
        .kind_o        (slot_kind)
    );

    tsw_resume_select #(
        .PC_W (PC_W)
    ) resume_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .kind_i      (slot_kind),
        .cur_pc_i    (cur_pc_i),
        .next_pc_i   (next_pc_i),
        .switch_o    (switch_o),
        .resume_pc_o (resume_pc_o)
    );

endmodule

// File: rtl/tsw_trigger_checker.sv
`timescale 1ns/1ps
// Module: tsw_trigger_checker
// Temporal properties of the switch trigger, bound to the top module.
// Assumes: observes the top's ports and its instruction count.
module tsw_trigger_checker #(
    parameter int CNT_W = 16,
    parameter int PC_W  = 20
) (
    input logic             clk,
    input logic             rst_n,
    input logic             insn_valid_i,
    input logic             yield_i,
    input logic             irq_active_i,
    input logic [CNT_W-1:0] interval_i,
    input logic             mt_enable_i,
    input logic             single_task_i,
    input logic [PC_W-1:0]  cur_pc_i,
    input logic [PC_W-1:0]  next_pc_i,
    input logic             switch_o,
    input logic [PC_W-1:0]  resume_pc_o,
    input logic [CNT_W-1:0] insn_count
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    // A switch pulse always comes with a freshly cleared count.
    assert_count_cleared_R1: assert property (@(posedge clk) disable iff (!rst_n)
        switch_o |-> (insn_count == '0));

    // A due slot outside interrupt service produces a pulse with its own address.
    assert_preempt_fires_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_valid_i && mt_enable_i && !single_task_i && !irq_active_i &&
         (interval_i != '0) && (insn_count >= interval_i))
        |=> (switch_o && (resume_pc_o == $past(cur_pc_i))));

    // Zero interval: no pulse without a yield.
    assert_zero_interval_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((interval_i == '0) && !yield_i) |=> !switch_o);

    // Interrupt service: no pulse without a yield.
    assert_irq_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_active_i && !yield_i) |=> !switch_o);

    // Yield-only slot saves the following address.
    assert_yield_resume_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_valid_i && yield_i && mt_enable_i && !single_task_i &&
         !((interval_i != '0) && (insn_count >= interval_i) && !irq_active_i))
        |=> (switch_o && (resume_pc_o == $past(next_pc_i))));

    // Disabled or single-task: nothing switches.
    assert_disabled_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!mt_enable_i || single_task_i) |=> !switch_o);

    // Count at its ceiling never wraps to a small non-zero value.
    assert_no_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_count == CNT_MAX) |=> ((insn_count == CNT_MAX) || (insn_count == '0)));

    // Resume address changes only together with a pulse.
    assert_resume_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !switch_o |-> $stable(resume_pc_o) || $past(!rst_n));

endmodule

bind task_switch_trigger tsw_trigger_checker #(
    .CNT_W (CNT_W),
    .PC_W  (PC_W)
) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .insn_valid_i  (insn_valid_i),
    .yield_i       (yield_i),
    .irq_active_i  (irq_active_i),
    .interval_i    (interval_i),
    .mt_enable_i   (mt_enable_i),
    .single_task_i (single_task_i),
    .cur_pc_i      (cur_pc_i),
    .next_pc_i     (next_pc_i),
    .switch_o      (switch_o),
    .resume_pc_o   (resume_pc_o),
    .insn_count    (insn_count)
);

// File: tb/task_switch_trigger_tb_top.sv
`timescale 1ns/1ps
// Bench for task_switch_trigger: a fixed-seed random phase plus directed
// corner cases, checked against a behavioural model kept in the bench.
module task_switch_trigger_tb_top;

    localparam int CNT_W = 16;
    localparam int PC_W  = 20;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             insn_valid_i = 1'b0;
    logic             yield_i = 1'b0;
    logic             irq_active_i = 1'b0;
    logic [CNT_W-1:0] interval_i = '0;
    logic             mt_enable_i = 1'b0;
    logic             single_task_i = 1'b0;
    logic [PC_W-1:0]  cur_pc_i = '0;
    logic [PC_W-1:0]  next_pc_i = '0;
    logic             switch_o;
    logic [PC_W-1:0]  resume_pc_o;

    int checks = 0;
    int failures = 0;

    // Bench model state.
    int unsigned      m_cnt = 0;
    logic             exp_sw = 1'b0;
    logic [PC_W-1:0]  exp_pc = '0;
    string            exp_tag = "R10";
    string            force_tag = "";
    logic             pending = 1'b0;

    always #2.5 clk = ~clk;

    task_switch_trigger #(.CNT_W(CNT_W), .PC_W(PC_W)) dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .insn_valid_i  (insn_valid_i),
        .yield_i       (yield_i),
        .irq_active_i  (irq_active_i),
        .interval_i    (interval_i),
        .mt_enable_i   (mt_enable_i),
        .single_task_i (single_task_i),
        .cur_pc_i      (cur_pc_i),
        .next_pc_i     (next_pc_i),
        .switch_o      (switch_o),
        .resume_pc_o   (resume_pc_o)
    );

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    // Watchdog: an expired run is a failed check.
    initial begin
        #900us;
        checks++;
        failures++;
        $display("FAIL watchdog: run did not complete (actual hung, expected done)");
        finish_run();
    end

    // Compare outputs against the expectation from the previous slot.
    task automatic check_pending();
        if (!pending) return;
        checks++;
        if (switch_o !== exp_sw) begin
            failures++;
            $display("FAIL %s switch_o actual=%0b expected=%0b", exp_tag, switch_o, exp_sw);
        end
        checks++;
        if (resume_pc_o !== exp_pc) begin
            failures++;
            $display("FAIL %s resume_pc_o actual=%h expected=%h", exp_tag, resume_pc_o, exp_pc);
        end
    endtask

    // One slot: check last result, drive new inputs, advance the model.
    task automatic step(input logic v, input logic y, input logic irq,
                        input logic en, input logic single,
                        input logic [CNT_W-1:0] iv, input logic [PC_W-1:0] cpc);
        logic due, act, pre, yl;
        logic [PC_W-1:0] npc;
        @(negedge clk);
        check_pending();
        npc = cpc + 1'b1;
        insn_valid_i  = v;
        yield_i       = y;
        irq_active_i  = irq;
        mt_enable_i   = en;
        single_task_i = single;
        interval_i    = iv;
        cur_pc_i      = cpc;
        next_pc_i     = npc;
        due = (iv != 0) && (m_cnt >= iv);
        act = en && !single && v;
        pre = act && due && !irq;
        yl  = act && y;
        exp_sw = pre || yl;
        if (pre) exp_pc = cpc;
        else if (yl) exp_pc = npc;
        if (pre && y)                exp_tag = "R8";
        else if (pre)                exp_tag = "R6";
        else if (yl)                 exp_tag = "R5";
        else if (act && due && irq)  exp_tag = "R4";
        else if (v && (!en || single)) exp_tag = "R7";
        else if (v && iv == 0)       exp_tag = "R3";
        else                         exp_tag = "R2";
        if (force_tag != "") exp_tag = force_tag;
        if (exp_sw)      m_cnt = 0;
        else if (v && m_cnt < 32'hFFFF) m_cnt = m_cnt + 1;
        pending = 1'b1;
    endtask

    initial begin
        logic [PC_W-1:0] pc;
        void'($urandom(32'd20250611));
        pc = 20'h00100;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R10: state right after reset.
        checks++;
        if (switch_o !== 1'b0 || resume_pc_o !== '0) begin
            failures++;
            $display("FAIL R10 reset actual=%0b/%h expected=0/00000", switch_o, resume_pc_o);
        end

        // R1: counting skips idle slots; preempt after exactly 4 executed.
        force_tag = "R1";
        for (int i = 0; i < 4; i++) begin
            step(1, 0, 0, 1, 0, 16'd4, pc); pc = pc + 1;
            step(0, 0, 0, 1, 0, 16'd4, pc);
        end
        step(1, 0, 0, 1, 0, 16'd4, pc); pc = pc + 1;
        force_tag = "";

        // R4: due while interrupt active, released later.
        for (int i = 0; i < 6; i++) begin
            step(1, 0, 1, 1, 0, 16'd3, pc); pc = pc + 1;
        end
        step(0, 0, 0, 1, 0, 16'd3, pc);
        step(1, 0, 0, 1, 0, 16'd3, pc); pc = pc + 1;

        // R8: yield on the due slot.
        for (int i = 0; i < 2; i++) begin
            step(1, 0, 0, 1, 0, 16'd2, pc); pc = pc + 1;
        end
        step(1, 1, 0, 1, 0, 16'd2, pc); pc = pc + 1;

        // R5: plain yield; R7: yields ignored when disabled or single task.
        step(1, 1, 0, 1, 0, 16'd0, pc); pc = pc + 1;
        step(1, 1, 0, 0, 0, 16'd0, pc); pc = pc + 1;
        step(1, 1, 0, 1, 1, 16'd0, pc); pc = pc + 1;
        step(1, 1, 0, 1, 0, 16'd0, pc); pc = pc + 1;

        // Random phase.
        for (int i = 0; i < 3000; i++) begin
            step(($urandom % 10) < 8, ($urandom % 10) == 0, ($urandom % 7) == 0,
                 ($urandom % 10) != 0, ($urandom % 10) == 0,
                 16'($urandom % 9), 20'($urandom));
        end

        // R9: a very long run with preemption off, then a maximal interval.
        step(1, 1, 0, 1, 0, 16'd0, pc); pc = pc + 1;
        for (int i = 0; i < 70000; i++) begin
            step(1, 0, 0, 1, 0, 16'd0, pc); pc = pc + 1;
        end
        force_tag = "R9";
        step(1, 0, 0, 1, 0, 16'hFFFF, pc); pc = pc + 1;
        step(0, 0, 0, 1, 0, 16'h0000, pc);
        force_tag = "";

        @(negedge clk);
        check_pending();
        finish_run();
    end

endmodule